// File: doc/BRIEF.md
# Serial Byte-Write Register Slave

This block is a serial slave that exposes a small file of 16-bit registers to an external master over a four-wire serial link. The link runs in clock mode 3 (clock idles high, data launched on falling edges and captured on rising edges). Every transfer is a 16-bit frame, most significant bit first. The top bit selects write (1) or read (0). The next seven bits give a byte address, and the low eight bits carry write data. Because each register spans two byte addresses, a write changes only one byte of a register. A read is answered during the following frame. In that following frame the master may already send the next request, so a stream of reads runs at one register per frame.

The serial pins are oversampled in the system clock domain. The serial clock must run below a quarter of the system clock. Word 0 is a read-only status word that holds two sticky flags. The first is a framing error: chip select was released after a bit count that is not a multiple of 16. The second is a capture violation: the link was used while the external function reported itself busy. Word 1 is a command word whose bits stay pending until the function behind them signals completion. One bit of it clears the status flags at once. The remaining words are plain configuration registers, presented on a flat parallel bus. Words past the configured count are reserved.

Top module: `spi_regfile_slave`

## Requirements
- R1: A frame is 16 rising serial-clock edges inside one chip-select-low period, sampled MSB first. Bit 15 = 1 marks a write, bits 14:8 are the byte address, bits 7:0 are write data (ignored on reads). Consecutive frames may share one chip-select-low period.
- R2: Register word k has low byte at byte address 2k and high byte at 2k+1. A write to one byte leaves the other byte unchanged. For words 2 and above, word k appears on `cfg_q[(k-2)*16 +: 16]`.
- R3: The frame after a read shifts out the full 16-bit register addressed by that read, MSB first, while its own DIN content is decoded as a new request. The frame after a write shifts out 0x0000.
- R4: DOUT changes only after a falling serial-clock edge. `dout_oe` is low whenever chip select is high.
- R5: Releasing chip select after a bit count that is not a multiple of 16 sets status bit 0. The bit stays set across later valid frames until cleared.
- R6: Writing 1 to a bit of word 1 (byte 0x02 for bits 7:0, byte 0x03 for bits 15:8) sets that bit of `cmd_pend`. The bit holds until the matching `cmd_done` bit is high for a cycle. Writing 0 has no effect. Reading word 1 returns the pending bits.
- R7: Writing 1 to word 1 bit 4 clears both status flags at once. That bit never shows as pending.
- R8: Chip select low while `busy` is high sets status bit 1, sticky until cleared. `busy` with chip select high has no effect.
- R9: Words at index 8 and above (byte addresses 0x10 and up) read as zero and ignore writes. Writes to word 0 are ignored.
- R10: A completed write frame is visible on `cfg_q` or `cmd_pend` within a few system clocks after its 16th rising edge. After reset all registers, flags and pending bits are zero and `dout_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the master, idles high |
| cs_n | input | 1 | Chip select, active low |
| din | input | 1 | Serial data from the master |
| dout | output | 1 | Serial data to the master |
| dout_oe | output | 1 | Output enable for the DOUT driver |
| busy | input | 1 | Capture in progress in the function behind the registers |
| cmd_done | input | 16 | Per-bit completion strobes for pending commands |
| cmd_pend | output | 16 | Pending command bits |
| cfg_q | output | 96 | Configuration words 2..7, word 2 in the low 16 bits |

## Verification
The assertions take the serial clock to be slow against the system clock, so that no two recognised rising edges fall in adjacent system cycles. They also take `cmd_done` to be a qualified strobe. The bench keeps each serial half-period at six system clocks and changes DIN and chip select only while the serial clock is low or idle. It raises `cmd_done` for one cycle at a time and only when no write frame is completing. With those limits, a frame completion, a falling-edge DOUT update and a register write never meet in the same cycle.

// File: rtl/spi_rf_pkg.sv
// Package: shared frame layout and fixed register indices for the serial
// register slave. The frame format is fixed at 16 bits by the link protocol.
package spi_rf_pkg;
    localparam int FRAME_W = 16;

    // One serial frame as seen after the 16th rising edge.
    typedef struct packed {
        logic       wr;     // 1 = write
        logic [6:0] addr;   // byte address
        logic [7:0] data;   // write data, ignored on reads
    } spi_frame_t;

    localparam int STATUS_WORD = 0;
    localparam int CMD_WORD    = 1;
    localparam int FIRST_CFG   = 2;
endpackage

// File: rtl/spi_rf_sync.sv
// Synchronizer: brings WIDTH asynchronous inputs into the clk domain through
// STAGES flops. Assumes the inputs are level signals held for several clocks.
module spi_rf_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    // Shift chain: stage 0 samples the pins, each later stage the one before.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/spi_rf_shifter.sv
// Frame engine: counts rising serial-clock edges inside chip-select-low,
// assembles 16-bit frames, flags short frames on chip-select release and
// drives DOUT from the response word on falling edges.
// Assumes synchronized inputs and a serial clock below clk/4.
module spi_rf_shifter
    import spi_rf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               cs_n_s,
    input  logic               din_s,
    input  logic [FRAME_W-1:0] rd_data,
    output logic               cs_active,
    output logic               frame_valid,
    output spi_frame_t         frame_word,
    output logic               frame_err,
    output logic               dout_q
);
    localparam int CNT_W = $clog2(FRAME_W);

    logic               sclk_d;
    logic               cs_n_d;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-2:0] shift_q;
    logic [FRAME_W-1:0] tx_word;
    logic               sclk_rise;
    logic               sclk_fall;

    assign sclk_rise   = sclk_s & ~sclk_d;
    assign sclk_fall   = ~sclk_s & sclk_d;
    assign cs_active   = ~cs_n_s;
    assign frame_word  = {shift_q, din_s};
    assign frame_valid = cs_active & sclk_rise & (bit_cnt == CNT_W'(FRAME_W-1));
    assign frame_err   = cs_n_s & ~cs_n_d & (bit_cnt != '0);

    // Edge history for the serial clock and chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b1;
            cs_n_d <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            cs_n_d <= cs_n_s;
        end
    end

    // Input shift register and bit counter, cleared while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shift_q <= '0;
        end else if (!cs_active) begin
            bit_cnt <= '0;
        end else if (sclk_rise) begin
            shift_q <= frame_word[FRAME_W-2:0];
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Response word: read data for a read frame, zero after a write frame.
    always_ff @(posedge clk) begin
        if (!rst_n)          tx_word <= '0;
        else if (frame_valid) tx_word <= frame_word.wr ? '0 : rd_data;
    end

    // DOUT launch: the bit for the coming rising edge, on each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                     dout_q <= 1'b0;
        else if (cs_active && sclk_fall) dout_q <= tx_word[~bit_cnt];
    end

    p_one_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);
    p_dout_fall_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(dout_q));
    p_idle_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> (bit_cnt == '0));
endmodule

// File: rtl/spi_rf_regs.sv
// Register file: status flags (word 0), self-clearing command bits (word 1)
// and NUM_WORDS-2 byte-writable configuration words. Reserved words read 0.
// Assumes frame_valid is a single-cycle strobe and NUM_WORDS <= 64.
module spi_rf_regs
    import spi_rf_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    parameter int CLR_BIT   = 4,
    localparam int CFG_WORDS = NUM_WORDS - FIRST_CFG,
    localparam int IDX_W     = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_valid,
    input  spi_frame_t                 frame_word,
    input  logic                       frame_err,
    input  logic                       cs_active,
    input  logic                       busy,
    input  logic [FRAME_W-1:0]         cmd_done,
    output logic [FRAME_W-1:0]         rd_data,
    output logic [FRAME_W-1:0]         cmd_pend,
    output logic [CFG_WORDS*FRAME_W-1:0] cfg_q
);
    logic [IDX_W-1:0]   idx;
    logic               hi_byte;
    logic               wr_hit;
    logic               clr_cmd;
    logic               spi_err;
    logic               viol;
    logic [FRAME_W-1:0] cmd_set;

    assign idx     = frame_word.addr[6:1];
    assign hi_byte = frame_word.addr[0];
    assign wr_hit  = frame_valid & frame_word.wr;
    assign clr_cmd = wr_hit & (idx == IDX_W'(CMD_WORD)) & ~hi_byte & frame_word.data[CLR_BIT];

    // Command bits requested by this write; the clear bit acts at once.
    always_comb begin
        cmd_set = '0;
        if (wr_hit && idx == IDX_W'(CMD_WORD)) begin
            if (hi_byte) cmd_set[15:8] = frame_word.data;
            else         cmd_set[7:0]  = frame_word.data;
        end
        cmd_set[CLR_BIT] = 1'b0;
    end

    // Sticky status flags, set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spi_err <= 1'b0;
            viol    <= 1'b0;
        end else begin
            spi_err <= (spi_err & ~clr_cmd) | frame_err;
            viol    <= (viol & ~clr_cmd) | (busy & cs_active);
        end
    end

    // Pending command bits, held until the matching completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_pend <= '0;
        else        cmd_pend <= (cmd_pend & ~cmd_done) | cmd_set;
    end

    // One byte-writable configuration word per generate iteration.
    for (genvar k = 0; k < CFG_WORDS; k++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[k*FRAME_W +: FRAME_W] <= '0;
            end else if (wr_hit && idx == IDX_W'(k + FIRST_CFG)) begin
                if (hi_byte) cfg_q[k*FRAME_W+8 +: 8] <= frame_word.data;
                else         cfg_q[k*FRAME_W   +: 8] <= frame_word.data;
            end
        end
    end

    // Read mux for the word addressed by the completing frame.
    always_comb begin
        rd_data = '0;
        if (idx == IDX_W'(STATUS_WORD))   rd_data = {14'd0, viol, spi_err};
        else if (idx == IDX_W'(CMD_WORD)) rd_data = cmd_pend;
        else if (idx < IDX_W'(NUM_WORDS)) rd_data = cfg_q[(idx - IDX_W'(FIRST_CFG))*FRAME_W +: FRAME_W];
    end

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_err && !clr_cmd) |=> spi_err);
    p_err_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> spi_err);
    p_viol_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cs_active) |=> viol);
    p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_pend & ~cmd_done) != '0) |=> (($past(cmd_pend & ~cmd_done) & ~cmd_pend) == '0));
    p_clr_not_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |=> !cmd_pend[CLR_BIT]);
    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (idx >= IDX_W'(NUM_WORDS)) |-> (rd_data == '0));
endmodule

// File: rtl/spi_regfile_slave.sv
// Top: serial mode-3 register slave. Synchronizes the pins, runs the frame
// engine and the register file. Assumes sclk below clk/4 and cs_n/din stable
// around rising serial-clock edges.
module spi_regfile_slave
    import spi_rf_pkg::*;
#(
    parameter int NUM_WORDS   = 8,
    parameter int SYNC_STAGES = 2,
    parameter int CLR_BIT     = 4,
    localparam int CFG_W      = (NUM_WORDS - FIRST_CFG) * FRAME_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               cs_n,
    input  logic               din,
    output logic               dout,
    output logic               dout_oe,
    input  logic               busy,
    input  logic [FRAME_W-1:0] cmd_done,
    output logic [FRAME_W-1:0] cmd_pend,
    output logic [CFG_W-1:0]   cfg_q
);
    logic [2:0]         pins_s;
    logic               cs_active;
    logic               frame_valid;
    logic               frame_err;
    spi_frame_t         frame_word;
    logic [FRAME_W-1:0] rd_data;

    spi_rf_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sclk, cs_n, din}),
        .sync_out (pins_s)
    );

    spi_rf_shifter u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_s      (pins_s[2]),
        .cs_n_s      (pins_s[1]),
        .din_s       (pins_s[0]),
        .rd_data     (rd_data),
        .cs_active   (cs_active),
        .frame_valid (frame_valid),
        .frame_word  (frame_word),
        .frame_err   (frame_err),
        .dout_q      (dout)
    );

    spi_rf_regs #(.NUM_WORDS(NUM_WORDS), .CLR_BIT(CLR_BIT)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (frame_valid),
        .frame_word  (frame_word),
        .frame_err   (frame_err),
        .cs_active   (cs_active),
        .busy        (busy),
        .cmd_done    (cmd_done),
        .rd_data     (rd_data),
        .cmd_pend    (cmd_pend),
        .cfg_q       (cfg_q)
    );

    assign dout_oe = cs_active;

    p_oe_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pins_s[1]) |-> !dout_oe);
endmodule

// File: tb/spi_regfile_slave_bench.sv
module spi_regfile_slave_bench;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        cs_n = 1'b1;
    logic        din = 1'b0;
    logic        busy = 1'b0;
    logic [15:0] cmd_done = '0;
    logic        dout;
    logic        dout_oe;
    logic [15:0] cmd_pend;
    logic [95:0] cfg_q;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    spi_regfile_slave u_spi_regfile_slave (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
        .dout(dout), .dout_oe(dout_oe), .busy(busy), .cmd_done(cmd_done),
        .cmd_pend(cmd_pend), .cfg_q(cfg_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_low();
        @(negedge clk); cs_n = 1'b0; clks(HALF);
    endtask

    task automatic cs_high();
        clks(HALF); cs_n = 1'b1; clks(8);
    endtask

    // Shift the top n bits of tx; returns the bits sampled on DOUT.
    task automatic spi_bits(input logic [15:0] tx, input int n, output logic [15:0] rx);
        rx = '0;
        for (int i = 15; i > 15 - n; i--) begin
            @(negedge clk); sclk = 1'b0; din = tx[i];
            clks(HALF);
            rx[i] = dout;
            sclk = 1'b1;
            clks(HALF);
        end
    endtask

    task automatic xfer(input logic [15:0] tx, output logic [15:0] rx);
        spi_bits(tx, 16, rx);
    endtask

    task automatic wr8(input logic [6:0] a, input logic [7:0] d);
        logic [15:0] r;
        cs_low(); xfer({1'b1, a, d}, r); cs_high();
    endtask

    task automatic rd16(input logic [6:0] a, output logic [15:0] v);
        logic [15:0] r;
        cs_low(); xfer({1'b0, a, 8'h00}, r); xfer(16'h0000, v); cs_high();
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R10 dout_oe", 32'(dout_oe), 0);
        chk("R10 cfg_q", cfg_q[31:0], 0);
        chk("R10 cmd_pend", 32'(cmd_pend), 0);
        rd16(7'h00, v);
        chk("R10 status", 32'(v), 0);
    endtask

    task automatic t_byte_write();
        wr8(7'h04, 8'h34);
        wr8(7'h05, 8'h12);
        chk("R2 word2 both bytes", 32'(cfg_q[15:0]), 32'h1234);
        wr8(7'h04, 8'hAB);
        chk("R2 low byte only", 32'(cfg_q[15:0]), 32'h12AB);
        wr8(7'h06, 8'h5A);
        wr8(7'h07, 8'hA5);
        chk("R10 word3 visible", 32'(cfg_q[31:16]), 32'hA55A);
    endtask

    task automatic t_read_pipeline();
        logic [15:0] r;
        cs_low();
        xfer(16'h0400, r);
        xfer(16'h0600, r);
        chk("R3 pipelined word2", 32'(r), 32'h12AB);
        xfer(16'h87C3, r);
        chk("R1 R3 word3 MSB first", 32'(r), 32'hA55A);
        xfer(16'h0000, r);
        chk("R3 after write", 32'(r), 0);
        cs_high();
        chk("R1 write in shared CS", 32'(cfg_q[31:16]), 32'hC35A);
    endtask

    task automatic t_reserved();
        logic [15:0] v;
        wr8(7'h10, 8'hFF);
        rd16(7'h10, v);
        chk("R9 reserved low", 32'(v), 0);
        rd16(7'h11, v);
        chk("R9 reserved high", 32'(v), 0);
        wr8(7'h00, 8'hFF);
        rd16(7'h00, v);
        chk("R9 status write ignored", 32'(v), 0);
        chk("R9 cfg untouched", cfg_q[31:0], 32'hC35A12AB);
    endtask

    task automatic t_command();
        logic [15:0] v;
        wr8(7'h02, 8'h01);
        chk("R6 set bit0", 32'(cmd_pend), 32'h0001);
        wr8(7'h02, 8'h00);
        chk("R6 zero write no effect", 32'(cmd_pend), 32'h0001);
        rd16(7'h02, v);
        chk("R6 read pending", 32'(v), 32'h0001);
        wr8(7'h03, 8'h80);
        chk("R6 high byte bit15", 32'(cmd_pend), 32'h8001);
        @(negedge clk); cmd_done = 16'h0001; @(negedge clk); cmd_done = '0; clks(2);
        chk("R6 done bit0", 32'(cmd_pend), 32'h8000);
        @(negedge clk); cmd_done = 16'h8000; @(negedge clk); cmd_done = '0; clks(2);
        chk("R6 done bit15", 32'(cmd_pend), 0);
    endtask

    task automatic t_frame_error();
        logic [15:0] r, v;
        cs_low(); spi_bits(16'h0000, 8, r); cs_high();
        rd16(7'h00, v);
        chk("R5 short frame flagged", 32'(v), 32'h0001);
        rd16(7'h00, v);
        chk("R5 sticky", 32'(v), 32'h0001);
        wr8(7'h02, 8'h10);
        rd16(7'h00, v);
        chk("R7 cleared", 32'(v), 0);
        chk("R7 not pending", 32'(cmd_pend), 0);
    endtask

    task automatic t_violation();
        logic [15:0] v;
        @(negedge clk); busy = 1'b1; clks(20); busy = 1'b0;
        rd16(7'h00, v);
        chk("R8 busy idle link", 32'(v), 0);
        @(negedge clk); busy = 1'b1;
        cs_low(); clks(4); cs_high();
        @(negedge clk); busy = 1'b0;
        rd16(7'h00, v);
        chk("R8 violation flagged", 32'(v), 32'h0002);
        wr8(7'h02, 8'h10);
        rd16(7'h00, v);
        chk("R7 violation cleared", 32'(v), 0);
    endtask

    task automatic t_tristate();
        chk("R4 oe idle", 32'(dout_oe), 0);
        cs_low();
        chk("R4 oe selected", 32'(dout_oe), 1);
        cs_high();
        chk("R4 oe released", 32'(dout_oe), 0);
    endtask

    initial begin
        clks(5);
        rst_n = 1'b1;
        clks(4);
        t_reset();
        t_byte_write();
        t_read_pipeline();
        t_reserved();
        t_command();
        t_frame_error();
        t_violation();
        t_tristate();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule